// File: doc/BRIEF.md
# Octal DDR PSRAM Mode-Register Access Engine

This engine runs single register transactions on an octal pseudo-static RAM. A host presents one request: an operation, a 32-bit register address, two bytes to write and a read latency in memory clocks. The engine frames the transaction with an active-low chip select and a memory clock made from the system clock. It drives the eight data lines through separate output-value and output-enable signals, samples returning bytes on both edges of the device's read strobe, and reports completion with a one-cycle done pulse and an error flag.

A transaction opens with a one-byte instruction held for a whole memory clock. Register accesses continue with the address, one byte per half clock, over two clocks. A write then sends its two data bytes in the next clock with no wait. A read releases the bus, idles for the programmed number of latency clocks, then takes one byte on each edge of the strobe. A reset sends the instruction only. Chip select then stays high for a minimum recovery time before the engine takes another request.

Top module: `opsram_reg_engine`

## Requirements
- R1: `req_op` selects the instruction byte sent: 0 is a register write and sends 0xC0, 1 is a register read and sends 0x40, 2 and 3 are a device reset and send 0xFF.
- R2: The instruction byte is driven with `dq_oe` high during both halves of the first memory clock after chip select falls.
- R3: For register writes and reads, the four address bytes follow the instruction, most significant first, one byte per half-period of `mem_ck`, across two memory clocks.
- R4: A write sends `req_wdata[7:0]` and then `req_wdata[15:8]` in the two halves of the clock directly after the address, with no dummy clocks and with `dq_oe` held high, then raises chip select.
- R5: A read drops `dq_oe` after the last address half and lets exactly `req_lat` memory clocks pass before it accepts a strobe edge; strobe edges seen inside that window are ignored.
- R6: On a read, the first rising edge of `dqs_in` after the latency loads `dq_in` into `rdata[7:0]` and the next falling edge loads `rdata[15:8]`; done then pulses with `error` low.
- R7: If the read strobe does not complete a pulse within `DQS_TO_CK` memory clocks after the latency, the read ends with done and `error` both high, chip select high and, when no rising edge arrived, `rdata` equal to zero.
- R8: A reset transaction consists only of the instruction clock: one rising edge of `mem_ck`, no address bytes, then chip select high.
- R9: Between transactions chip select stays high for at least `CS_GAP_CK` memory clocks (`2*CS_GAP_CK*CLK_DIV` system clocks), and `mem_ck` is low whenever chip select is high.
- R10: A request is taken only when `busy` is low; `req_valid` while busy has no effect on the bus; `done` is a single-cycle pulse with `busy` already low.
- R11: While chip select is low, each half-period of `mem_ck` lasts `CLK_DIV` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 2 | Operation: 0 write, 1 read, 2 or 3 reset |
| req_addr | input | 32 | Register address |
| req_wdata | input | 16 | Write bytes, low byte sent first |
| req_lat | input | LAT_W | Read latency in memory clocks |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Read strobe timeout, valid with done |
| rdata | output | 16 | Captured read bytes |
| mem_ck | output | 1 | Memory clock, low at rest |
| mem_cs_n | output | 1 | Active-low chip select |
| dq_o | output | 8 | Data line output value |
| dq_oe | output | 1 | Data line output enable |
| dq_in | input | 8 | Data line input value |
| dqs_in | input | 1 | Read data strobe from the device |

## Verification
The hardest case to reach is a strobe pulse that lands inside the latency window, since a correct device never sends one there; the bench's device model is told to emit a junk pulse with junk data on the last dummy clock and the proper pulse one clock later, so only a design that respects the window returns the right bytes. A silent device drives the timeout path, and a long latency stresses the dummy counter at its top value. Requests are issued back to back, and one is pulsed in the middle of a write, to expose both the chip-select recovery time and the busy guard.

// File: rtl/opsram_reg_engine.sv
module opsram_reg_engine #(
  parameter int CLK_DIV   = 2,
  parameter int LAT_W     = 6,
  parameter int DQS_TO_CK = 8,
  parameter int CS_GAP_CK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [31:0]      req_addr,
  input  logic [15:0]      req_wdata,
  input  logic [LAT_W-1:0] req_lat,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [15:0]      rdata,
  output logic             mem_ck,
  output logic             mem_cs_n,
  output logic [7:0]       dq_o,
  output logic             dq_oe,
  input  logic [7:0]       dq_in,
  input  logic             dqs_in
);

  localparam int DIV_W      = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int TO_HALVES  = 2 * DQS_TO_CK;
  localparam int GAP_HALVES = 2 * CS_GAP_CK;
  localparam int TO_W       = $clog2(TO_HALVES + 1);
  localparam int GAP_W      = $clog2(GAP_HALVES + 1);
  localparam int HW0        = (LAT_W + 1 > TO_W) ? LAT_W + 1 : TO_W;
  localparam int HW         = (HW0 > GAP_W) ? HW0 : GAP_W;

  localparam logic [7:0] OPC_WR  = 8'hC0;
  localparam logic [7:0] OPC_RD  = 8'h40;
  localparam logic [7:0] OPC_RST = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_WDATA, S_RWAIT, S_RDATA, S_GAP
  } state_t;

  state_t             st;
  logic [DIV_W-1:0]   div_cnt;
  logic [HW-1:0]      half;
  logic               ck_q, cs_n_q, err_q, done_q, dqs_q;
  logic [1:0]         op_q;
  logic [31:0]        addr_q;
  logic [15:0]        wdata_q, rdata_q;
  logic [LAT_W-1:0]   lat_q;
  logic [7:0]         opcode, dq_v;

  wire tick       = (st != S_IDLE) && (div_cnt == DIV_W'(CLK_DIV - 1));
  wire dummy_end  = (half == HW'({lat_q, 1'b0}) - HW'(1));
  wire to_end     = tick && (half == HW'(TO_HALVES - 1));
  wire dqs_rise   = dqs_in && !dqs_q;
  wire dqs_fall   = !dqs_in && dqs_q;

  assign opcode   = op_q[1] ? OPC_RST : (op_q[0] ? OPC_RD : OPC_WR);
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign error    = done_q & err_q;
  assign rdata    = rdata_q;
  assign mem_ck   = ck_q;
  assign mem_cs_n = cs_n_q;
  assign dq_oe    = (st == S_CMD) || (st == S_ADDR) || (st == S_WDATA);
  assign dq_o     = dq_v;

  always_comb begin
    case (st)
      S_CMD:   dq_v = opcode;
      S_ADDR:  dq_v = 8'(addr_q >> {~half[1:0], 3'b000});
      S_WDATA: dq_v = half[0] ? wdata_q[15:8] : wdata_q[7:0];
      default: dq_v = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      div_cnt <= '0;
      half    <= '0;
      ck_q    <= 1'b0;
      cs_n_q  <= 1'b1;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      dqs_q   <= 1'b0;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      lat_q   <= '0;
    end else begin
      done_q <= 1'b0;
      dqs_q  <= dqs_in;
      if (st == S_IDLE || tick) div_cnt <= '0;
      else                      div_cnt <= div_cnt + 1'b1;
      if (tick) begin
        half <= half + 1'b1;
        if (st != S_GAP) ck_q <= ~ck_q;
      end
      case (st)
        S_IDLE: if (req_valid) begin
          op_q    <= req_op;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          lat_q   <= req_lat;
          rdata_q <= '0;
          err_q   <= 1'b0;
          half    <= '0;
          ck_q    <= 1'b0;
          cs_n_q  <= 1'b0;
          st      <= S_CMD;
        end
        S_CMD: if (tick && half[0]) begin
          half <= '0;
          if (op_q[1]) begin
            st <= S_GAP; cs_n_q <= 1'b1; ck_q <= 1'b0; div_cnt <= '0;
          end else begin
            st <= S_ADDR;
          end
        end
        S_ADDR: if (tick && half[1:0] == 2'd3) begin
          half <= '0;
          if (!op_q[0])         st <= S_WDATA;
          else if (lat_q == '0) st <= S_RWAIT;
          else                  st <= S_DUMMY;
        end
        S_DUMMY: if (tick && dummy_end) begin
          half <= '0;
          st   <= S_RWAIT;
        end
        S_WDATA: if (tick && half[0]) begin
          st <= S_GAP; half <= '0; cs_n_q <= 1'b1; ck_q <= 1'b0; div_cnt <= '0;
        end
        S_RWAIT: begin
          if (dqs_rise) begin
            rdata_q[7:0] <= dq_in;
            st           <= S_RDATA;
          end else if (to_end) begin
            err_q <= 1'b1;
            st <= S_GAP; half <= '0; cs_n_q <= 1'b1; ck_q <= 1'b0; div_cnt <= '0;
          end
        end
        S_RDATA: begin
          if (dqs_fall) begin
            rdata_q[15:8] <= dq_in;
            st <= S_GAP; half <= '0; cs_n_q <= 1'b1; ck_q <= 1'b0; div_cnt <= '0;
          end else if (to_end) begin
            err_q <= 1'b1;
            st <= S_GAP; half <= '0; cs_n_q <= 1'b1; ck_q <= 1'b0; div_cnt <= '0;
          end
        end
        S_GAP: if (tick && half == HW'(GAP_HALVES - 1)) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/opsram_reg_engine_chk.sv
module opsram_reg_engine_chk #(
  parameter int CLK_DIV   = 2,
  parameter int CS_GAP_CK = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic error,
  input logic mem_ck,
  input logic mem_cs_n,
  input logic dq_oe
);

  localparam int GAP_MIN = 2 * CS_GAP_CK * CLK_DIV;

  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hi_cnt <= '1;
    else if (!mem_cs_n)          hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;
  end

  p_drive_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !mem_cs_n);

  p_ck_rest_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> !mem_ck);

  p_cs_recovery_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> (hi_cnt >= 16'(GAP_MIN)));

  p_done_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_error_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done);

  p_accept_opens_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> (busy && !mem_cs_n));

endmodule

bind opsram_reg_engine opsram_reg_engine_chk #(
  .CLK_DIV(CLK_DIV), .CS_GAP_CK(CS_GAP_CK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .error(error), .mem_ck(mem_ck), .mem_cs_n(mem_cs_n), .dq_oe(dq_oe)
);

// File: tb/opsram_reg_engine_test.sv
module opsram_reg_engine_test;
  localparam int DIV = 2;
  localparam int LW  = 6;
  localparam int TO  = 8;
  localparam int GAP = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [LW-1:0] req_lat = '0;
  logic busy, done, error, mem_ck, mem_cs_n, dq_oe;
  logic [15:0] rdata;
  logic [7:0] dq_o;
  logic [7:0] dq_drv = 8'h00;
  logic dqs_drv = 1'b0;

  always #4 clk = ~clk;

  opsram_reg_engine #(.CLK_DIV(DIV), .LAT_W(LW), .DQS_TO_CK(TO), .CS_GAP_CK(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_lat(req_lat),
    .busy(busy), .done(done), .error(error), .rdata(rdata),
    .mem_ck(mem_ck), .mem_cs_n(mem_cs_n), .dq_o(dq_o), .dq_oe(dq_oe),
    .dq_in(dq_drv), .dqs_in(dqs_drv)
  );

  int checks = 0, failures = 0;
  logic [7:0] strm [0:15];
  int sc = 0, rises = 0, since = 0, per_bad = 0, rr = 0;
  int cs_hi = 0, gap_bad = 0;
  bit started = 0, real_p = 0;
  logic ck_p = 1'b0, cs_p = 1'b1;
  int cur_mode = 0, cur_lat = 0;
  logic [15:0] cur_d = '0;
  int cyc = 0;

  // {op, addr, wdata, lat, device read bytes, device mode}; mode 0 normal, 1 early junk pulse, 2 silent
  localparam logic [75:0] VECS [9] = '{
    {2'd0, 32'h0000_0000, 16'h0D2C, 8'd0,  16'h0000, 2'd0},
    {2'd1, 32'h0000_0000, 16'h0000, 8'd5,  16'h0D2C, 2'd0},
    {2'd0, 32'h0000_0004, 16'h05A3, 8'd0,  16'h0000, 2'd0},
    {2'd1, 32'h0000_0004, 16'h0000, 8'd0,  16'h05A3, 2'd0},
    {2'd2, 32'h0000_0000, 16'h0000, 8'd0,  16'h0000, 2'd0},
    {2'd1, 32'h0000_0008, 16'h0000, 8'd3,  16'h0861, 2'd1},
    {2'd1, 32'h1234_5678, 16'h0000, 8'd2,  16'hBEEF, 2'd2},
    {2'd0, 32'hDEAD_BEEF, 16'h8001, 8'd0,  16'h0000, 2'd0},
    {2'd1, 32'h0000_A5C3, 16'h0000, 8'd63, 16'hFF00, 2'd0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // device and bus monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!mem_cs_n) begin
      if (cs_p) begin
        if (started && cs_hi < 2 * GAP * DIV) gap_bad++;
        started = 1;
      end
      if (dq_oe && (cs_p || mem_ck != ck_p) && sc < 16) begin
        strm[sc] = dq_o;
        sc++;
      end
      if (mem_ck && !ck_p) begin
        if (rises > 0 && since != 2 * DIV) per_bad++;
        since = 0;
        rises++;
        if (!dq_oe) begin
          rr++;
          if (cur_mode == 1 && cur_lat > 0 && rr == cur_lat) begin
            dqs_drv = 1'b1; dq_drv = 8'hEE;
          end
          if (cur_mode != 2 && rr == cur_lat + 1) begin
            dqs_drv = 1'b1; dq_drv = cur_d[7:0]; real_p = 1;
          end
        end
      end else if (!mem_ck && ck_p && dqs_drv) begin
        dqs_drv = 1'b0;
        dq_drv = real_p ? cur_d[15:8] : 8'h11;
      end
      since++;
      cs_hi = 0;
    end else begin
      cs_hi++;
      rr = 0;
      real_p = 0;
      dqs_drv = 1'b0;
      dq_drv = 8'h00;
    end
    ck_p = mem_ck;
    cs_p = mem_cs_n;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=<190000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run_txn(input logic [1:0] op, input logic [31:0] a, input logic [15:0] wd,
                         input logic [7:0] lat, input logic [15:0] rd, input logic [1:0] md,
                         input bit poke);
    logic [7:0] exp [0:7];
    int elen, n, er;
    logic [15:0] got_rd;
    logic got_err;
    cur_mode = int'(md); cur_lat = int'(lat); cur_d = rd;
    sc = 0; rises = 0;
    req_op = op; req_addr = a; req_wdata = wd; req_lat = lat[LW-1:0]; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      if (poke && n == 3) begin req_valid = 1'b1; req_op = 2'd2; end
      else req_valid = 1'b0;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    chk(n < 20000, "R10", "done reached", n, 20000);
    got_rd = rdata; got_err = error;
    exp[0] = op[1] ? 8'hFF : (op[0] ? 8'h40 : 8'hC0);
    exp[1] = exp[0];
    exp[2] = a[31:24]; exp[3] = a[23:16]; exp[4] = a[15:8]; exp[5] = a[7:0];
    exp[6] = wd[7:0];  exp[7] = wd[15:8];
    elen = op[1] ? 2 : (op[0] ? 6 : 8);
    chk(sc == elen, op[1] ? "R8" : (op[0] ? "R5" : "R4"), "driven byte count", sc, elen);
    for (int i = 0; i < elen && i < sc; i++)
      chk(strm[i] == exp[i], i < 2 ? "R1/R2" : (i < 6 ? "R3" : "R4"),
          $sformatf("byte %0d", i), strm[i], exp[i]);
    if (op[1]) chk(rises == 1, "R8", "clock rises in reset", rises, 1);
    else if (!op[0]) chk(rises == 4, "R4", "clock rises in write", rises, 4);
    chk(mem_cs_n == 1'b1, "R9", "cs high at done", mem_cs_n, 1);
    er = (op == 2'd1 && md == 2'd2) ? 1 : 0;
    chk(got_err == er[0], er ? "R7" : "R6", "error flag", got_err, er);
    if (op == 2'd1)
      chk(got_rd == (er ? 16'h0000 : rd), er ? "R7" : (md == 2'd1 ? "R5" : "R6"),
          "read bytes", got_rd, er ? 16'h0000 : rd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_cs_n == 1'b1 && mem_ck == 1'b0 && dq_oe == 1'b0 && busy == 1'b0 && done == 1'b0,
        "R9", "reset state", {mem_cs_n, mem_ck, dq_oe, busy, done}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    for (int v = 0; v < 9; v++)
      run_txn(VECS[v][75:74], VECS[v][73:42], VECS[v][41:26], VECS[v][25:18],
              VECS[v][17:2], VECS[v][1:0], 1'b0);
    // R10: request pulsed mid-write must not disturb the frame
    run_txn(2'd0, 32'h0000_0008, 16'h0408, 8'd0, 16'h0000, 2'd0, 1'b1);
    chk(busy == 1'b0, "R10", "idle after poked write", busy, 0);
    // R1: op 3 behaves as reset
    run_txn(2'd3, 32'hFFFF_FFFF, 16'hFFFF, 8'd0, 16'h0000, 2'd0, 1'b0);
    // R6: latency one, normal device
    run_txn(2'd1, 32'h0000_0010, 16'h0000, 8'd1, 16'h7E81, 2'd0, 1'b0);
    repeat (4) @(negedge clk);
    chk(per_bad == 0, "R11", "half-period length errors", per_bad, 0);
    chk(gap_bad == 0, "R9", "short cs recovery count", gap_bad, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule